// File: doc/BRIEF.md
# Buffered Programmed-I/O Read Controller

This block sits between a CPU register bus and a simple word-oriented device. Software starts a read with a command write. The device side then streams words into a small internal buffer at its own pace, and software does other work while this happens. When the buffer fill ends, the controller raises a level interrupt. Software then drains the buffer one word at a time. For each word it writes a fetch command and then reads the data register.

The CPU reaches four byte-wide registers, selected by a 2-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | command | write; reads as zero |
| 1 | status | read |
| 2 | data-in | read; holds the fetched word |
| 3 | data-out | read/write; drives a device-facing output |

Bus reads are combinational from the address. Writes and read side effects take place at the rising clock edge.

Top module: `pio_buf_ctrl`

## Requirements
- R1: After reset, status reads 0x08 (empty only), the data-in register reads 0x00, and irq_o, dev_req_o and dev_out_o are all low.
- R2: Writing 0x01 to the command register while idle makes the controller busy: dev_req_o rises after the write edge and status bit 0 reads 1. The same write discards the previous buffer contents and clears the error and data-valid bits.
- R3: While busy, each cycle with dev_valid_i high stores dev_data_i at the next buffer slot, in order. The fill ends at a word that has dev_last_i set, or at the 16th word, whichever comes first. Once the fill ends, dev_req_o drops and further device words are ignored.
- R4: irq_o rises at the clock edge that accepts the final word of a fill. It stays high until a status register read, and it is low after that read.
- R5: Writing 0x02 while idle with words remaining loads the oldest unread word into the data-in register and sets status bit 2 (data valid). A read of the data-in register clears bit 2.
- R6: Writing 0x02 while idle with no words remaining sets status bit 4 (error) and leaves the data-in register unchanged. Bit 4 stays set until the next accepted start.
- R7: Command value 0x00, any value other than 0x01 or 0x02, a start while busy, and a fetch while busy all leave the status and the buffer untouched.
- R8: The status byte is laid out as follows:
  - bit 0: busy
  - bit 1: ready (idle with words remaining)
  - bit 2: data valid
  - bit 3: empty (no words remaining)
  - bit 4: error
  - bits 7 to 5: zero
- R9: A write to register 3 stores the byte, drives it on dev_out_o from the next cycle, and the byte reads back at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (drives read side effects) |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |
| irq_o | output | 1 | Level interrupt: buffer fill finished |
| dev_req_o | output | 1 | Fill request to the device, high while busy |
| dev_valid_i | input | 1 | Device word strobe |
| dev_last_i | input | 1 | Marks the device word as the final one |
| dev_data_i | input | 8 | Device word |
| dev_out_o | output | 8 | Contents of the data-out register |

## Verification
Corrupt fill or read pointers do not stay hidden. They show up as a wrong byte on the very next fetch-and-read pair, or as an empty, ready or error flag in the wrong state on the next status read. An interrupt bookkeeping fault shows up on irq_o within one cycle of the final device word or of the status read. A decode fault, where an ignored code still does something, shows up in the status byte read straight after that command.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DIN  = 2'd2;
  localparam logic [1:0] REG_DOUT = 2'd3;

  localparam int unsigned CMD_START = 1;
  localparam int unsigned CMD_FETCH = 2;

  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_READY = 1;
  localparam int unsigned ST_VALID = 2;
  localparam int unsigned ST_EMPTY = 3;
  localparam int unsigned ST_ERR   = 4;
  localparam int unsigned ST_BITS  = 5;
endpackage

// File: rtl/pio_cmd_dec.sv
module pio_cmd_dec #(
  parameter int unsigned DW = 8
) (
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          start_o,
  output logic          fetch_o
);
  import pio_pkg::*;

  logic cmd_wr;

  assign cmd_wr  = we_i && (addr_i == REG_CMD);
  assign start_o = cmd_wr && (wdata_i == DW'(CMD_START));
  assign fetch_o = cmd_wr && (wdata_i == DW'(CMD_FETCH));
endmodule

// File: rtl/pio_buf.sv
module pio_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pio_buf_ctrl.sv
module pio_buf_ctrl #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          dev_req_o,
  input  logic          dev_valid_i,
  input  logic          dev_last_i,
  input  logic [DW-1:0] dev_data_i,
  output logic [DW-1:0] dev_out_o
);
  import pio_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          busy_q, dv_q, err_q, irq_q;
  logic [CW-1:0] wr_cnt_q, rd_cnt_q, remain;
  logic [DW-1:0] data_q, dout_q, buf_rd;
  logic [DW-1:0] stat;
  logic          start, fetch, do_start, do_fetch, fetch_err;
  logic          accept, fill_done, empty, stat_rd, din_rd;

  pio_cmd_dec #(.DW(DW)) u_dec (
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .start_o (start),
    .fetch_o (fetch)
  );

  pio_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept),
    .wr_addr_i (wr_cnt_q[AW-1:0]),
    .wr_data_i (dev_data_i),
    .rd_addr_i (rd_cnt_q[AW-1:0]),
    .rd_data_o (buf_rd)
  );

  assign remain    = wr_cnt_q - rd_cnt_q;
  assign empty     = (remain == '0);
  assign accept    = busy_q && dev_valid_i;
  assign fill_done = accept && (dev_last_i || (wr_cnt_q == CW'(DEPTH - 1)));
  assign do_start  = start && !busy_q;
  assign do_fetch  = fetch && !busy_q && !empty;
  assign fetch_err = fetch && !busy_q && empty;
  assign stat_rd   = bus_re_i && (bus_addr_i == REG_STAT);
  assign din_rd    = bus_re_i && (bus_addr_i == REG_DIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      dv_q     <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      data_q   <= '0;
      dout_q   <= '0;
    end else begin
      if (do_start) begin
        busy_q   <= 1'b1;
        wr_cnt_q <= '0;
        rd_cnt_q <= '0;
        dv_q     <= 1'b0;
        err_q    <= 1'b0;
      end else begin
        if (fill_done) busy_q <= 1'b0;
        if (accept) wr_cnt_q <= wr_cnt_q + 1'b1;
        if (do_fetch) begin
          data_q   <= buf_rd;
          rd_cnt_q <= rd_cnt_q + 1'b1;
          dv_q     <= 1'b1;
        end else if (din_rd) begin
          dv_q <= 1'b0;
        end
        if (fetch_err) err_q <= 1'b1;
      end
      // completion wins over a same-cycle clear
      if (fill_done)    irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
      if (bus_we_i && (bus_addr_i == REG_DOUT)) dout_q <= bus_wdata_i;
    end
  end

  always_comb begin
    stat           = '0;
    stat[ST_BUSY]  = busy_q;
    stat[ST_READY] = !busy_q && !empty;
    stat[ST_VALID] = dv_q;
    stat[ST_EMPTY] = empty;
    stat[ST_ERR]   = err_q;
  end

  always_comb begin
    case (bus_addr_i)
      REG_STAT: bus_rdata_o = stat;
      REG_DIN:  bus_rdata_o = data_q;
      REG_DOUT: bus_rdata_o = dout_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_q;
  assign dev_req_o = busy_q;
  assign dev_out_o = dout_q;
endmodule

// File: rtl/pio_buf_ctrl_chk.sv
module pio_buf_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_we_i,
  input logic          bus_re_i,
  input logic [1:0]    bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic          dev_valid_i,
  input logic          dev_last_i,
  input logic          dev_req_o,
  input logic          irq_o,
  input logic [DW-1:0] data_q,
  input logic [DW-1:0] stat
);
  logic cmd_wr, stat_rd;
  assign cmd_wr  = bus_we_i && (bus_addr_i == 2'd0);
  assign stat_rd = bus_re_i && (bus_addr_i == 2'd1);

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_req_o && cmd_wr && bus_wdata_i == DW'(1)) |=> dev_req_o);

  // R3
  fill_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_o && dev_valid_i && dev_last_i) |=> !dev_req_o);

  // R4
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_rd) |=> irq_o);

  // R4
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !dev_req_o) |=> !irq_o);

  // R6
  err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && bus_wdata_i == DW'(2) && stat[3] && !stat[0]) |=> ($stable(data_q) && stat[4]));

  // R8
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat[1] && (stat[3] || stat[0])));
endmodule

bind pio_buf_ctrl pio_buf_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_re_i    (bus_re_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .dev_valid_i (dev_valid_i),
  .dev_last_i  (dev_last_i),
  .dev_req_o   (dev_req_o),
  .irq_o       (irq_o),
  .data_q      (data_q),
  .stat        (stat)
);

// File: tb/pio_buf_ctrl_test.sv
`timescale 1ns/1ps
module pio_buf_ctrl_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, dreq;
  logic       dvalid = 1'b0, dlast = 1'b0;
  logic [7:0] ddata = '0, dout;

  always #2.5 clk = ~clk;

  pio_buf_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .dev_req_o(dreq), .dev_valid_i(dvalid),
    .dev_last_i(dlast), .dev_data_i(ddata), .dev_out_o(dout)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] m_buf [DEPTH];
  int   m_wr = 0, m_rd = 0;
  bit   m_busy = 0, m_dv = 0, m_err = 0, m_irq = 0;
  logic [7:0] m_data = '0;

  function automatic logic [7:0] exp_stat();
    return {3'b000, m_err, (m_wr == m_rd), m_dv, (!m_busy && m_wr != m_rd), m_busy};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); re = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d);
    wr_reg(2'd0, d);
    if (!m_busy && d == 8'h01) begin
      m_busy = 1; m_wr = 0; m_rd = 0; m_dv = 0; m_err = 0;
    end else if (!m_busy && d == 8'h02) begin
      if (m_wr != m_rd) begin
        m_data = m_buf[m_rd]; m_rd++; m_dv = 1;
      end else m_err = 1;
    end
  endtask

  task automatic rd_stat(string req);
    logic [7:0] v;
    rd_reg(2'd1, v);
    check(req, v, exp_stat());
    m_irq = 0;
  endtask

  task automatic rd_data(string req);
    logic [7:0] v;
    rd_reg(2'd2, v);
    check(req, v, m_data);
    m_dv = 0;
  endtask

  task automatic push(logic [7:0] d, bit last);
    @(negedge clk); dvalid = 1'b1; ddata = d; dlast = last;
    @(negedge clk); dvalid = 1'b0; dlast = 1'b0;
    if (m_busy) begin
      m_buf[m_wr] = d; m_wr++;
      if (last || m_wr == DEPTH) begin m_busy = 0; m_irq = 1; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", {irq, dreq}, 2'b00);
    check("R1", dout, 8'h00);
    rst_n = 1'b1;
    rd_stat("R1");
    rd_data("R1");

    // fetch straight after reset: nothing buffered
    cmd(8'h02);
    rd_stat("R6");
    rd_data("R6");

    for (int round = 0; round < 30; round++) begin
      int n;
      logic [7:0] ig;
      ig = 8'($urandom);
      if (ig == 8'h01 || ig == 8'h02) ig = 8'h00;
      cmd(ig);
      rd_stat("R7");

      cmd(8'h01);
      check("R2", dreq, 1'b1);
      rd_stat("R2");

      n = 1 + int'($urandom % 20);
      if (round == 0) n = 20;
      if (round == 1) n = 1;
      for (int i = 0; i < n; i++) begin
        push(8'($urandom), (n <= DEPTH) && (i == n - 1));
        check("R3", dreq, m_busy);
        if (i == 0 && n > 2) begin
          cmd(8'h01);
          cmd(8'h02);
          cmd(8'h7f);
          rd_stat("R7");
        end
        repeat ($urandom % 3) @(negedge clk);
      end

      check("R4", irq, 1'b1);
      @(negedge clk);
      check("R4", irq, 1'b1);
      rd_stat("R8");
      check("R4", irq, 1'b0);

      while (m_rd < m_wr) begin
        if ($urandom % 4 == 0) begin
          cmd(8'h00);
          rd_stat("R7");
        end
        cmd(8'h02);
        if ($urandom % 2 == 0) rd_stat("R5");
        rd_data("R5");
      end
      rd_stat("R5");

      cmd(8'h02);
      rd_stat("R6");
      rd_data("R6");

      v = 8'($urandom);
      wr_reg(2'd3, v);
      check("R9", dout, v);
      begin
        logic [7:0] rb;
        rd_reg(2'd3, rb);
        check("R9", rb, v);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule